// File: doc/BRIEF.md
# Interlocked Glitch-Free Base Clock Selector

This block picks the base clock of a subsystem from one of two running sources: a reference oscillator clock and a clock from a phase-locked loop's VCO. Software controls it through a small control register. The register has a PLL enable bit, which drives the `pll_en` output that powers the loop, and a source-select bit. Hardware interlocks the two bits, so the VCO clock can never be chosen while the loop is off, and the loop cannot be turned off while its clock is in use. Turning on the VCO clock from a cold loop therefore takes two writes: first enable, then select.

A source change never produces a runt pulse. The old source is gated off on its own falling edge. Its gated-off state is then carried into the other clock domain through a synchroniser. Only after that is the new source gated on, again on its own falling edge. Between the two steps the output is held low. A busy flag in the read data shows when a handover is still running. A stop-mode input forces the selection back to the oscillator.

The control register lives in the oscillator domain and samples writes on the rising edge of `osc_clk`.

Top module: `base_clk_mux`

## Requirements
- R1: Reset sets the PLL enable bit to 1 and the select bit to 0. Once the oscillator gate has opened, `rd_data` reads 8'h20. Read data layout: bit 7 is busy, bit 5 is PLL enable, bit 4 is select, and all other bits read 0.
- R2: The `pll_en` output always equals the PLL enable bit of the register.
- R3: A write with `wr_pll_on`=0 while the select bit is 1 leaves the PLL enable bit at 1.
- R4: A write with `wr_use_vco`=1 while the PLL enable bit is 0 leaves the select bit at 0. Selecting the VCO from a disabled loop takes a write of enable first and a write of select after it.
- R5: When one write changes both bits, each interlock is judged against the register contents from before that write. Writing both bits as 1 from 8'h00 gives 8'h20. Writing both bits as 0 from 8'h30 gives 8'h20.
- R6: While `stop_req` is 1, the select bit is forced to 0 and the PLL enable bit is not changed.
- R7: The busy bit reads 1 from the clock edge that changes the select bit until the new source is running. It clears within 30 oscillator cycles.
- R8: After a select change, `base_clk` runs at the newly selected source's period (8 ns for the oscillator, 6 ns for the VCO in the bench). No gap in its edges exceeds 3 oscillator periods plus 4 VCO periods.
- R9: `base_clk` never makes a pulse shorter than the shorter source half period. During a handover it rests low: no high phase is longer than the longer source half period. The two source gates are never open at the same time.
- R10: After reset, `base_clk` follows the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Reference oscillator clock; also clocks the control register |
| vco_clk | input | 1 | VCO clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop mode; forces oscillator selection while high |
| wr_en | input | 1 | Register write strobe, sampled on `osc_clk` rising edge |
| wr_pll_on | input | 1 | Write value for the PLL enable bit |
| wr_use_vco | input | 1 | Write value for the source-select bit |
| rd_data | output | 8 | Register read: bit 7 busy, bit 5 PLL enable, bit 4 select |
| pll_en | output | 1 | Enable to the PLL |
| base_clk | output | 1 | Selected glitch-free base clock |
| switch_busy | output | 1 | Handover in progress |

## Verification
The hardest condition to reach is a write that changes both interlocked bits at once. It has to hit a register that is already in the one state where each bit's legality depends on the other's old value. The bench first walks the register through the two-write enable-then-select sequence to reach 8'h30, then issues a single write that clears both bits. It also issues a double set from 8'h00. While all of this runs, an edge monitor times every high and low phase of `base_clk`, so that runt pulses and overlong freezes are caught across every handover in the run.

// File: rtl/base_clk_pkg.sv
`timescale 1ns/1ps
package base_clk_pkg;
    localparam int REG_W    = 8;
    localparam int BUSY_BIT = 7;
    localparam int PLL_BIT  = 5;
    localparam int SEL_BIT  = 4;

    typedef struct packed {
        logic pll_on;
        logic use_vco;
        logic busy;
    } ctl_t;

    typedef struct packed {
        logic gate;
    } gate_t;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/clk_gate_chain.sv
`timescale 1ns/1ps
module clk_gate_chain
    import base_clk_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic gate_o
);
    logic  req_sync;
    gate_t st_d, st_q;

    bit_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (req),
        .dout (req_sync)
    );

    // Gate moves only while its own clock is low.
    always_comb begin
        st_d      = st_q;
        st_d.gate = req_sync;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;
endmodule

// File: rtl/ctrl_reg.sv
`timescale 1ns/1ps
module ctrl_reg
    import base_clk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_pll_on,
    input  logic wr_use_vco,
    input  logic stop_req,
    input  logic osc_on,
    input  logic vco_on_seen,
    output ctl_t ctl_o
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            // Both interlocks use the pre-write contents.
            ctl_d.pll_on  = ctl_q.use_vco ? 1'b1 : wr_pll_on;
            ctl_d.use_vco = ctl_q.pll_on ? wr_use_vco : 1'b0;
        end
        if (stop_req) ctl_d.use_vco = 1'b0;
        ctl_d.busy = ctl_d.use_vco ? !vco_on_seen : !osc_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.pll_on  <= 1'b1;
            ctl_q.use_vco <= 1'b0;
            ctl_q.busy    <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/base_clk_mux.sv
`timescale 1ns/1ps
module base_clk_mux
    import base_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             wr_en,
    input  logic             wr_pll_on,
    input  logic             wr_use_vco,
    output logic [REG_W-1:0] rd_data,
    output logic             pll_en,
    output logic             base_clk,
    output logic             switch_busy
);
    ctl_t ctl;
    logic osc_gate, vco_gate, vco_gate_seen;
    logic osc_req, vco_req;

    ctrl_reg u_ctrl (
        .clk        (osc_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_pll_on  (wr_pll_on),
        .wr_use_vco (wr_use_vco),
        .stop_req   (stop_req),
        .osc_on     (osc_gate),
        .vco_on_seen(vco_gate_seen),
        .ctl_o      (ctl)
    );

    always_comb begin
        osc_req = !ctl.use_vco && !vco_gate;
        vco_req =  ctl.use_vco && !osc_gate;
    end

    clk_gate_chain #(.STAGES(SYNC_STAGES)) u_osc_gate (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .req   (osc_req),
        .gate_o(osc_gate)
    );

    clk_gate_chain #(.STAGES(SYNC_STAGES)) u_vco_gate (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .req   (vco_req),
        .gate_o(vco_gate)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_vco_seen (
        .clk  (osc_clk),
        .rst_n(rst_n),
        .din  (vco_gate),
        .dout (vco_gate_seen)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[BUSY_BIT] = ctl.busy;
        rd_data[PLL_BIT]  = ctl.pll_on;
        rd_data[SEL_BIT]  = ctl.use_vco;
    end

    assign pll_en      = ctl.pll_on;
    assign switch_busy = ctl.busy;
    assign base_clk    = (osc_clk & osc_gate) | (vco_clk & vco_gate);
endmodule

// File: rtl/base_clk_mux_chk.sv
`timescale 1ns/1ps
module base_clk_mux_chk
    import base_clk_pkg::*;
(
    input logic             osc_clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic             wr_en,
    input logic             wr_pll_on,
    input logic [REG_W-1:0] rd_data,
    input logic             pll_en,
    input logic             osc_gate,
    input logic             vco_gate
);
    // R4
    sel_needs_pll_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        rd_data[SEL_BIT] |-> pll_en);

    // R3
    pll_held_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (wr_en && !wr_pll_on && rd_data[SEL_BIT]) |=> pll_en);

    // R6
    stop_clears_sel_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        stop_req |=> !rd_data[SEL_BIT]);

    // R6
    stop_keeps_pll_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (stop_req && !wr_en) |=> $stable(pll_en));

    // R9
    gates_exclusive_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !(osc_gate && vco_gate));

    // R7
    busy_on_change_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (rd_data[SEL_BIT] != $past(rd_data[SEL_BIT])) |-> rd_data[BUSY_BIT]);
endmodule

bind base_clk_mux base_clk_mux_chk u_chk (
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .wr_en    (wr_en),
    .wr_pll_on(wr_pll_on),
    .rd_data  (rd_data),
    .pll_en   (pll_en),
    .osc_gate (osc_gate),
    .vco_gate (vco_gate)
);

// File: tb/base_clk_mux_bench.sv
`timescale 1ns/1ps
module base_clk_mux_bench;
    logic osc_clk = 1'b0;
    logic vco_clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0;
    logic wr_en = 1'b0;
    logic wr_pll_on = 1'b0;
    logic wr_use_vco = 1'b0;
    logic [7:0] rd_data;
    logic pll_en, base_clk, switch_busy;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 osc_clk = ~osc_clk;   // 125 MHz
    always #3 vco_clk = ~vco_clk;

    base_clk_mux u_base_clk_mux (
        .osc_clk    (osc_clk),
        .vco_clk    (vco_clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .wr_en      (wr_en),
        .wr_pll_on  (wr_pll_on),
        .wr_use_vco (wr_use_vco),
        .rd_data    (rd_data),
        .pll_en     (pll_en),
        .base_clk   (base_clk),
        .switch_busy(switch_busy)
    );

    // Edge monitor for base_clk phases
    bit    mon_on = 0;
    realtime t_rise = 0.0, t_fall = 0.0;
    real   max_high = 0.0, max_gap = 0.0;
    int    runts = 0, freezes = 0;

    always @(posedge base_clk) begin
        if (mon_on && t_fall > 0.0) begin
            if ($realtime - t_fall < 2.9) runts++;
            if ($realtime - t_fall > 4.5) begin
                freezes++;
                if ($realtime - t_fall > max_gap) max_gap = $realtime - t_fall;
            end
        end
        t_rise = $realtime;
    end

    always @(negedge base_clk) begin
        if (mon_on && t_rise > 0.0) begin
            if ($realtime - t_rise < 2.9) runts++;
            if ($realtime - t_rise > max_high) max_high = $realtime - t_rise;
        end
        t_fall = $realtime;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input bit pll, input bit sel);
        @(negedge osc_clk);
        wr_en = 1'b1; wr_pll_on = pll; wr_use_vco = sel;
        @(negedge osc_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (rd_data[7] && n < 30) begin
            @(negedge osc_clk);
            n++;
        end
        check(rd_data[7] == 1'b0, tag, n, 30);
    endtask

    task automatic measure_period(input int exp_ns, input string tag);
        realtime t0;
        repeat (2) @(posedge base_clk);
        t0 = $realtime;
        @(posedge base_clk);
        check(($realtime - t0) > exp_ns - 0.1 && ($realtime - t0) < exp_ns + 0.1,
              tag, int'($realtime - t0), exp_ns);
        @(negedge osc_clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        rst_n = 1'b1;
        repeat (10) @(negedge osc_clk);
        check(rd_data == 8'h20, "R1 reset value", rd_data, 8'h20);
        check(pll_en == 1'b1, "R2 pll_en after reset", pll_en, 1);
        mon_on = 1;
        measure_period(8, "R10 osc after reset");
    endtask

    task automatic t_sel_needs_pll();
        reg_write(1'b0, 1'b0);
        check(rd_data == 8'h00, "R2 pll off", rd_data, 8'h00);
        check(pll_en == 1'b0, "R2 pll_en low", pll_en, 0);
        reg_write(1'b0, 1'b1);
        check(rd_data == 8'h00, "R4 select refused", rd_data, 8'h00);
        measure_period(8, "R4 still osc");
        reg_write(1'b1, 1'b0);
        check(rd_data == 8'h20, "R4 first write enables", rd_data, 8'h20);
        reg_write(1'b1, 1'b1);
        check(rd_data[5:4] == 2'b11, "R4 second write selects", rd_data[5:4], 3);
        check(rd_data[7] == 1'b1, "R7 busy on select", rd_data[7], 1);
        check(switch_busy == 1'b1, "R7 busy port", switch_busy, 1);
        wait_idle("R7 busy clears to vco");
        measure_period(6, "R8 vco period");
    endtask

    task automatic t_pll_hold_and_both();
        // from 8'h30, clear both in one write
        reg_write(1'b0, 1'b0);
        check(rd_data[5:4] == 2'b10, "R3 R5 pll held, sel cleared", rd_data[5:4], 2);
        check(pll_en == 1'b1, "R3 pll_en held", pll_en, 1);
        wait_idle("R7 busy clears to osc");
        measure_period(8, "R8 back on osc");
        reg_write(1'b0, 1'b0);
        check(rd_data == 8'h00, "R5 pll now clears", rd_data, 8'h00);
        reg_write(1'b1, 1'b1);
        check(rd_data == 8'h20, "R5 double set from off", rd_data, 8'h20);
    endtask

    task automatic t_stop();
        reg_write(1'b1, 1'b1);
        wait_idle("R7 to vco before stop");
        @(negedge osc_clk);
        stop_req = 1'b1;
        @(negedge osc_clk);
        check(rd_data[5:4] == 2'b10, "R6 stop clears sel", rd_data[5:4], 2);
        reg_write(1'b1, 1'b1);
        check(rd_data[4] == 1'b0, "R6 select blocked in stop", rd_data[4], 0);
        stop_req = 1'b0;
        wait_idle("R7 busy clears after stop");
        measure_period(8, "R6 osc after stop");
    endtask

    initial begin
        t_reset();
        t_sel_needs_pll();
        t_pll_hold_and_both();
        t_stop();
        repeat (5) @(negedge osc_clk);
        check(runts == 0, "R9 no runt pulses", runts, 0);
        check(max_high < 4.1, "R9 rests low in hold", int'(max_high), 4);
        check(freezes > 0, "R8 handovers seen", freezes, 1);
        check(max_gap <= 48.0, "R8 freeze bound", int'(max_gap), 48);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule